// File: doc/BRIEF.md
# Dual-Port Serial Master for an Audio Decoder

This block drives the two serial ports of an external compressed-audio decoder from a single clock domain. The first port carries register traffic. The host pulses a start request and supplies a direction, an address and a 16-bit value. The block then runs one 32-bit serial transaction: an instruction byte, the address, and then sixteen data bits. On a read, the sixteen bits returned by the decoder appear on a parallel output when the transaction completes.

The second port carries the compressed audio stream. The host offers bytes over a valid/ready handshake. Each byte is shifted out under its own chip-select window, but only while the decoder holds its data-request line high. Both ports idle with the serial clock low. Both launch data while the clock is low so that the decoder can sample on the rising edge. The two ports have separate state and timing, so a register access and audio streaming can run at the same time. The serial half-period, in system clocks, and the chip-select recovery time after a register transaction are parameters.

Top module: `dec_spi_master`

## Requirements
- R1: Out of reset and whenever a port is idle, its serial clock is low, its chip select is high and its serial data output is low. The read-data output resets to zero.
- R2: A register transaction holds the control chip select low for exactly 32 serial clock pulses. It shifts out MSB first an instruction byte (0x03 for read when `reg_write` is 0, 0x02 for write when `reg_write` is 1), then the 8-bit address, then the 16 write-data bits.
- R3: Each serial clock level lasts `HALF_CLKS` system clocks. The first low level starts at the clock edge that accepts the request. The serial data output changes only at that edge or at a falling serial clock edge, never while the clock is high.
- R4: In a read, the control input is sampled at the rising serial clock edges of the last 16 pulses, MSB first. That value is presented on `reg_rdata` from the `reg_done` pulse onward. Input levels during the instruction and address pulses have no effect on `reg_rdata`.
- R5: A write transaction leaves `reg_rdata` unchanged.
- R6: `reg_busy` rises at the accepting edge and stays high until the done pulse. After the last pulse, the control chip select stays high for `GAP_HALVES*HALF_CLKS` system clocks before `reg_busy` falls. A `reg_start` seen while busy is ignored.
- R7: `reg_done` is a one-cycle pulse, (64+`GAP_HALVES`)*`HALF_CLKS` clocks after the accepting edge. A `reg_start` held high starts the next transaction on the clock after the pulse.
- R8: An audio byte is accepted when `aud_valid`, `aud_dreq` and an idle data port coincide, and `aud_ready` equals idle-and-request. The byte is sent MSB first as 8 pulses under a data chip select that is low for 16*`HALF_CLKS` clocks.
- R9: When `aud_dreq` falls during a byte, that byte completes unchanged and no further byte starts until `aud_dreq` is high again.
- R10: Register transactions and audio bytes proceed concurrently without altering each other's timing or content.
- R11: Between consecutive audio bytes the data chip select is high for at least one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_start | input | 1 | Request a register transaction |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write value |
| reg_rdata | output | DATA_W | Value returned by the last read |
| reg_busy | output | 1 | Register transaction in progress |
| reg_done | output | 1 | One-cycle completion pulse |
| aud_valid | input | 1 | Audio byte offered |
| aud_byte | input | 8 | Audio byte value |
| aud_ready | output | 1 | Byte taken when valid is also high |
| aud_dreq | input | 1 | Decoder can take more audio |
| ctl_sclk | output | 1 | Control port serial clock |
| ctl_mosi | output | 1 | Control port serial data out |
| ctl_cs_n | output | 1 | Control port chip select, active low |
| ctl_miso | input | 1 | Control port serial data in |
| dat_sclk | output | 1 | Audio port serial clock |
| dat_mosi | output | 1 | Audio port serial data out |
| dat_cs_n | output | 1 | Audio port chip select, active low |

## Verification
Register traffic is exercised with writes and with reads whose returned words are all ones, all zeros, single-end patterns and mixed values, while random levels are driven on the input pin during the instruction and address pulses. A wrong capture window or a wrong bit order therefore shows up as a wrong read value. A request held high across two transactions, and a second request pulsed mid-transaction, separate correct back-to-back behaviour from re-triggering. Audio streaming is driven with a continuously asserted request, with the request dropped in mid-byte, and alongside a register read. These cases distinguish byte completion, gating by the request line and port independence.

// File: rtl/dspi_pkg.sv
// Shared constants and types for the dual-port decoder serial master.
package dspi_pkg;

    // Width of the instruction field that opens every register frame.
    localparam int OPC_W = 8;

    // Instruction codes placed in the first byte of a register frame.
    localparam logic [OPC_W-1:0] OPC_READ  = 8'h03;
    localparam logic [OPC_W-1:0] OPC_WRITE = 8'h02;

    // Serial phase of a port engine.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_GAP
    } phase_e;

endpackage

// File: rtl/dspi_half_timer.sv
// Half-period timer for one serial port.
// Counts system clocks while its port is active. It raises tick on the
// last clock of each serial clock level. Assumes HALF_CLKS >= 1. The
// count is held at zero while the port is idle, so the first level after
// a start is always a full HALF_CLKS long.
module dspi_half_timer #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);

    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = active && (cnt == CNT_LAST);

    // Advance within a level, restart at each level boundary or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dspi_reg_port.sv
// Register-access engine for the control serial port.
// On an accepted start it shifts out a frame made of instruction, address
// and data, MSB first, under one low chip-select window. It samples the
// serial input on every rising clock edge and keeps only the last DATA_W
// samples, so bits arriving during the instruction and address are
// dropped. After the last pulse the chip select recovers for GAP_HALVES
// serial levels, and then done pulses. Assumes GAP_HALVES >= 1.
module dspi_reg_port
    import dspi_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int HALF_CLKS  = 2,
    parameter int GAP_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);

    localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int GAP_W   = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_HALVES - 1);

    phase_e             state;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame;
    logic [BIT_W-1:0]   bitc;
    logic [GAP_W-1:0]   gapc;
    logic [DATA_W-1:0]  rx;
    logic               is_read;
    logic               tick;
    logic               accept;
    logic [OPC_W-1:0]   opcode;

    assign busy   = (state != PH_IDLE);
    assign accept = start && !busy;

    // Assemble the outgoing frame from the request fields.
    always_comb begin
        opcode = write ? OPC_WRITE : OPC_READ;
        frame  = {opcode, addr, wdata};
    end

    dspi_half_timer #(
        .HALF_CLKS(HALF_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .active(busy),
        .tick  (tick)
    );

    // Frame sequencer: launch on low levels, sample on rises, then recover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_IDLE;
            shreg   <= '0;
            bitc    <= '0;
            gapc    <= '0;
            rx      <= '0;
            rdata   <= '0;
            is_read <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            cs_n    <= 1'b1;
        end else begin
            done <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (accept) begin
                        shreg   <= frame;
                        bitc    <= '0;
                        is_read <= !write;
                        cs_n    <= 1'b0;
                        sclk    <= 1'b0;
                        mosi    <= frame[FRAME_W-1];
                        state   <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rx    <= {rx[DATA_W-2:0], miso};
                        state <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bitc == BIT_LAST) begin
                            cs_n  <= 1'b1;
                            mosi  <= 1'b0;
                            gapc  <= '0;
                            state <= PH_GAP;
                        end else begin
                            bitc  <= bitc + 1'b1;
                            shreg <= {shreg[FRAME_W-2:0], 1'b0};
                            mosi  <= shreg[FRAME_W-2];
                            state <= PH_LOW;
                        end
                    end
                end
                PH_GAP: begin
                    if (tick) begin
                        if (gapc == GAP_LAST) begin
                            gapc  <= '0;
                            done  <= 1'b1;
                            state <= PH_IDLE;
                            if (is_read) begin
                                rdata <= rx;
                            end
                        end else begin
                            gapc <= gapc + 1'b1;
                        end
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dspi_stream_port.sv
// Audio byte engine for the data serial port.
// Takes a byte when the host offers one, the decoder requests data and
// the port is idle. It sends the byte MSB first under its own chip-select
// window. A byte in flight always completes; the request line only gates
// the start of the next byte. Assumes aud_dreq is synchronous to clk.
module dspi_stream_port
    import dspi_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int HALF_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [BYTE_W-1:0] din,
    input  logic              dreq,
    output logic              ready,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    phase_e            state;
    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  bitc;
    logic              tick;
    logic              active;

    assign active = (state != PH_IDLE);
    assign ready  = !active && dreq;

    dspi_half_timer #(
        .HALF_CLKS(HALF_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .active(active),
        .tick  (tick)
    );

    // Byte sequencer: load on handshake, shift on falling levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            shreg <= '0;
            bitc  <= '0;
            sclk  <= 1'b0;
            mosi  <= 1'b0;
            cs_n  <= 1'b1;
        end else begin
            case (state)
                PH_IDLE: begin
                    if (valid && ready) begin
                        shreg <= din;
                        bitc  <= '0;
                        cs_n  <= 1'b0;
                        sclk  <= 1'b0;
                        mosi  <= din[BYTE_W-1];
                        state <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        state <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (bitc == BIT_LAST) begin
                            cs_n  <= 1'b1;
                            mosi  <= 1'b0;
                            state <= PH_IDLE;
                        end else begin
                            bitc  <= bitc + 1'b1;
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            mosi  <= shreg[BYTE_W-2];
                            state <= PH_LOW;
                        end
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dec_spi_master.sv
// Top of the dual-port decoder serial master.
// It joins an independent register engine and an audio byte engine. The
// ports share only clock and reset, so their traffic never interacts.
// Assumes all host inputs and aud_dreq are synchronous to clk.
module dec_spi_master #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int HALF_CLKS  = 2,
    parameter int GAP_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_start,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_busy,
    output logic              reg_done,
    input  logic              aud_valid,
    input  logic [7:0]        aud_byte,
    output logic              aud_ready,
    input  logic              aud_dreq,
    output logic              ctl_sclk,
    output logic              ctl_mosi,
    output logic              ctl_cs_n,
    input  logic              ctl_miso,
    output logic              dat_sclk,
    output logic              dat_mosi,
    output logic              dat_cs_n
);

    dspi_reg_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .HALF_CLKS (HALF_CLKS),
        .GAP_HALVES(GAP_HALVES)
    ) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .start(reg_start),
        .write(reg_write),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .busy (reg_busy),
        .done (reg_done),
        .sclk (ctl_sclk),
        .mosi (ctl_mosi),
        .cs_n (ctl_cs_n),
        .miso (ctl_miso)
    );

    dspi_stream_port #(
        .BYTE_W   (8),
        .HALF_CLKS(HALF_CLKS)
    ) u_stream (
        .clk  (clk),
        .rst_n(rst_n),
        .valid(aud_valid),
        .din  (aud_byte),
        .dreq (aud_dreq),
        .ready(aud_ready),
        .sclk (dat_sclk),
        .mosi (dat_mosi),
        .cs_n (dat_cs_n)
    );

endmodule

// File: rtl/dspi_checker.sv
// Protocol checker for the dual-port decoder serial master, bound to the top.
module dspi_checker (
    input logic clk,
    input logic rst_n,
    input logic reg_start,
    input logic reg_busy,
    input logic reg_done,
    input logic aud_valid,
    input logic aud_ready,
    input logic aud_dreq,
    input logic ctl_sclk,
    input logic ctl_mosi,
    input logic ctl_cs_n,
    input logic dat_sclk,
    input logic dat_mosi,
    input logic dat_cs_n
);

    AST_CTL_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_cs_n |-> !ctl_sclk); // R1

    AST_DAT_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dat_cs_n |-> !dat_sclk); // R1

    AST_CTL_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sclk |-> $stable(ctl_mosi)); // R3

    AST_DAT_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dat_sclk |-> $stable(dat_mosi)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |=> !reg_done); // R7

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done |-> (!reg_busy && ctl_cs_n)); // R6

    AST_CTL_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_cs_n) |-> ($past(reg_start) && !$past(reg_busy))); // R6

    AST_DAT_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_cs_n) |-> ($past(aud_dreq) && $past(aud_valid))); // R9

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        aud_ready |-> (dat_cs_n && aud_dreq)); // R8

endmodule

bind dec_spi_master dspi_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_start(reg_start),
    .reg_busy (reg_busy),
    .reg_done (reg_done),
    .aud_valid(aud_valid),
    .aud_ready(aud_ready),
    .aud_dreq (aud_dreq),
    .ctl_sclk (ctl_sclk),
    .ctl_mosi (ctl_mosi),
    .ctl_cs_n (ctl_cs_n),
    .dat_sclk (dat_sclk),
    .dat_mosi (dat_mosi),
    .dat_cs_n (dat_cs_n)
);

// File: tb/tb_dec_spi_master.sv
// Cycle-level bench: a behavioural timeline model predicts every output
// on every clock and is compared at the falling edge.
module tb_dec_spi_master;

    localparam int D         = 2;
    localparam int GAPH      = 2;
    localparam int CTL_END   = 64 * D;
    localparam int CTL_DONE  = CTL_END + GAPH * D;
    localparam int BYTE_END  = 16 * D;
    localparam int WD_LIMIT  = 60000;

    logic        clk;
    logic        rst_n;
    logic        reg_start;
    logic        reg_write;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        reg_busy;
    logic        reg_done;
    logic        aud_valid;
    logic [7:0]  aud_byte;
    logic        aud_ready;
    logic        aud_dreq;
    logic        ctl_sclk;
    logic        ctl_mosi;
    logic        ctl_cs_n;
    logic        ctl_miso;
    logic        dat_sclk;
    logic        dat_mosi;
    logic        dat_cs_n;

    dec_spi_master #(
        .ADDR_W    (8),
        .DATA_W    (16),
        .HALF_CLKS (D),
        .GAP_HALVES(GAPH)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_start(reg_start),
        .reg_write(reg_write),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .reg_busy (reg_busy),
        .reg_done (reg_done),
        .aud_valid(aud_valid),
        .aud_byte (aud_byte),
        .aud_ready(aud_ready),
        .aud_dreq (aud_dreq),
        .ctl_sclk (ctl_sclk),
        .ctl_mosi (ctl_mosi),
        .ctl_cs_n (ctl_cs_n),
        .ctl_miso (ctl_miso),
        .dat_sclk (dat_sclk),
        .dat_mosi (dat_mosi),
        .dat_cs_n (dat_cs_n)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Model state: start cycle of each transfer, or -1 when none.
    integer      cyc = 0;
    integer      c_ts = -1;
    integer      s_ts = -1;
    logic [31:0] c_frame = '0;
    logic        c_rd = 1'b0;
    logic [15:0] c_rval = '0;
    logic [15:0] exp_rdata = '0;
    logic [7:0]  s_byte = '0;
    logic [15:0] per_val = '0;
    logic [7:0]  q[$];
    logic        feed_en = 1'b0;
    integer      n_cmp = 0;
    integer      n_bad = 0;
    string       ovr = "R1";
    bit          finished = 1'b0;

    // Reference timeline update at each rising edge.
    always @(posedge clk) begin : model
        logic c_busy_b;
        logic s_busy_b;
        cyc = cyc + 1;
        if (!rst_n) begin
            c_ts      = -1;
            s_ts      = -1;
            exp_rdata = '0;
        end else begin
            c_busy_b = (c_ts >= 0) && ((cyc - 1 - c_ts) < CTL_DONE);
            if (c_ts >= 0 && (cyc - c_ts) == CTL_DONE && c_rd)
                exp_rdata = c_rval;
            if (reg_start && !c_busy_b) begin
                c_ts    = cyc;
                c_rd    = !reg_write;
                c_frame = {(reg_write ? 8'h02 : 8'h03), reg_addr, reg_wdata};
                c_rval  = per_val;
            end
            s_busy_b = (s_ts >= 0) && ((cyc - 1 - s_ts) < BYTE_END);
            if (aud_valid && aud_dreq && !s_busy_b) begin
                s_ts   = cyc;
                s_byte = q.pop_front();
            end
        end
    end

    task automatic chk(input string req, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     req, nm, act, exp, cyc);
        end
    endtask

    function automatic string tg(input string dflt);
        return (ovr != "") ? ovr : dflt;
    endfunction

    // Compare every output against the model, then drive peripheral-side inputs.
    always @(negedge clk) begin : compare
        integer o;
        integer so;
        integer b;
        logic e_cs, e_sclk, e_mosi, e_busy, e_done;
        logic d_cs, d_sclk, d_mosi, d_ready;
        if (!finished) begin
            o = (c_ts >= 0) ? (cyc - c_ts) : -1;
            e_cs = 1'b1; e_sclk = 1'b0; e_mosi = 1'b0; e_busy = 1'b0; e_done = 1'b0;
            if (o >= 0 && o < CTL_END) begin
                e_cs   = 1'b0;
                e_sclk = ((o / D) % 2) == 1;
                e_mosi = c_frame[31 - (o / D) / 2];
                e_busy = 1'b1;
            end else if (o >= CTL_END && o < CTL_DONE) begin
                e_busy = 1'b1;
            end else if (o == CTL_DONE) begin
                e_done = 1'b1;
            end
            chk(tg("R2"), "ctl_cs_n", 32'(ctl_cs_n), 32'(e_cs));
            chk(tg("R3"), "ctl_sclk", 32'(ctl_sclk), 32'(e_sclk));
            chk(tg("R2"), "ctl_mosi", 32'(ctl_mosi), 32'(e_mosi));
            chk(tg("R6"), "reg_busy", 32'(reg_busy), 32'(e_busy));
            chk(tg("R7"), "reg_done", 32'(reg_done), 32'(e_done));
            chk(tg("R4"), "reg_rdata", 32'(reg_rdata), 32'(exp_rdata));

            so = (s_ts >= 0) ? (cyc - s_ts) : -1;
            d_cs = 1'b1; d_sclk = 1'b0; d_mosi = 1'b0;
            if (so >= 0 && so < BYTE_END) begin
                d_cs   = 1'b0;
                d_sclk = ((so / D) % 2) == 1;
                d_mosi = s_byte[7 - (so / D) / 2];
            end
            d_ready = d_cs && aud_dreq;
            chk(tg("R11"), "dat_cs_n", 32'(dat_cs_n), 32'(d_cs));
            chk(tg("R8"), "dat_sclk", 32'(dat_sclk), 32'(d_sclk));
            chk(tg("R8"), "dat_mosi", 32'(dat_mosi), 32'(d_mosi));
            chk(tg("R9"), "aud_ready", 32'(aud_ready), 32'(d_ready));

            // Peripheral: data bits in the read data phase, random junk elsewhere.
            if (o >= 0 && o < CTL_END) begin
                b = (o / D) / 2;
                if (c_rd && b >= 16) ctl_miso = c_rval[31 - b];
                else                 ctl_miso = 1'($urandom % 2);
            end else begin
                ctl_miso = 1'($urandom % 2);
            end
            aud_valid = feed_en && (q.size() > 0);
            aud_byte  = (q.size() > 0) ? q[0] : 8'h00;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic reg_op(input logic wr, input logic [7:0] a,
                          input logic [15:0] wd, input logic [15:0] pv);
        per_val   = pv;
        reg_write = wr;
        reg_addr  = a;
        reg_wdata = wd;
        reg_start = 1'b1;
        step(1);
        reg_start = 1'b0;
        step(CTL_DONE + 3);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (!finished && cyc > WD_LIMIT) begin
            n_bad = n_bad + 1;
            $display("FAIL R1 watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; reg_start = 1'b0; reg_write = 1'b0; reg_addr = '0;
        reg_wdata = '0; aud_dreq = 1'b0; ctl_miso = 1'b0;
        aud_valid = 1'b0; aud_byte = '0;
        // R1: reset and idle state.
        ovr = "R1";
        step(5);
        rst_n = 1'b1;
        step(6);

        // R2/R3/R6/R7: plain write with default tags.
        ovr = "";
        reg_op(1'b1, 8'h0B, 16'hA55A, 16'h0000);

        // R4: read with junk during header bits.
        ovr = "R4";
        reg_op(1'b0, 8'h01, 16'h0000, 16'h1234);

        // R5: write must leave read data untouched.
        ovr = "R5";
        reg_op(1'b1, 8'h22, 16'h0F0F, 16'hBEEF);

        // R6: a second request during a busy read is ignored.
        ovr = "R6";
        per_val = 16'h8001; reg_write = 1'b0; reg_addr = 8'h40; reg_wdata = 16'h0;
        reg_start = 1'b1; step(1); reg_start = 1'b0;
        step(20);
        reg_write = 1'b1; reg_addr = 8'hEE; reg_wdata = 16'h7777; reg_start = 1'b1;
        step(1); reg_start = 1'b0;
        step(CTL_DONE + 3);

        // R7: request held high runs two transactions back to back.
        ovr = "R7";
        per_val = 16'hFFFF; reg_write = 1'b0; reg_addr = 8'h7F; reg_start = 1'b1;
        step(CTL_DONE + 5);
        reg_start = 1'b0;
        step(CTL_DONE + 3);
        ovr = "R4";
        reg_op(1'b0, 8'h80, 16'h0000, 16'h0000);

        // R8/R9/R11: continuous streaming with default tags.
        ovr = "";
        q.push_back(8'hA5); q.push_back(8'h3C); q.push_back(8'h00); q.push_back(8'hFF);
        aud_dreq = 1'b1; feed_en = 1'b1;
        step(4 * (BYTE_END + 1) + 6);

        // R9: request drops mid-byte; byte completes, no new byte.
        ovr = "R9";
        q.push_back(8'h81); q.push_back(8'h5E); q.push_back(8'hC7);
        step(5);
        aud_dreq = 1'b0;
        step(BYTE_END + 12);
        aud_dreq = 1'b1;
        step(2 * (BYTE_END + 1) + 6);

        // R10: register read concurrent with streaming.
        ovr = "R10";
        for (int i = 0; i < 6; i++) q.push_back(8'(8'h11 * (i + 1)));
        reg_op(1'b0, 8'h5A, 16'h0000, 16'hC3A5);
        step(6 * (BYTE_END + 1));
        ovr = "R11";
        q.push_back(8'h96); q.push_back(8'h69);
        step(2 * (BYTE_END + 1) + 6);

        finish_run();
    end

endmodule